// File: doc/BRIEF.md
# Checkpointed Register Rename Map

This block sits in a superscalar front end between decode and the issue queue. Each cycle it takes a group of up to four instructions, each with two architectural source registers and one architectural destination, and returns physical tags: the physical register each source currently lives in, a fresh physical register for each destination, and the physical register that destination pointed at before. Results live in a physical register file. Giving every destination a new register removes write-after-read and write-after-write hazards. Instructions later in a group see the renames made by earlier ones in the same group.

Every renamed instruction gets an in-flight slot number, and the map as it stands right after that instruction is saved in its slot. A flush names a slot: the map is reloaded from that slot's copy in one cycle, every younger instruction is dropped, and the registers those younger instructions took go back to the free list in the same cycle. Commit retires the oldest in-flight instruction and frees the register its destination replaced. Architectural register 31 is a hardwired zero. It is never renamed and uses no physical register.

Top module: `rename_map`

## Requirements
- R1: At reset, architectural register r (0 to 30) maps to physical tag r+1. A source of a valid or idle lane returns the tag currently mapped to that source.
- R2: A source naming register 31 returns tag 0. A destination naming register 31 returns 0 as both new and previous tag and allocates nothing.
- R3: At reset the free list holds tags 32 to NPHYS-1. Lanes that have a real destination take the lowest-numbered free tags, in lane order, and each lane's previous tag is the mapping that destination had before it.
- R4: A source that names the destination of an earlier valid lane in the same group gets the newest such lane's new tag instead of the stored mapping.
- R5: When a destination repeats the destination of an earlier lane in the group, its previous tag is that earlier lane's new tag.
- R6: `ren_ready` is low, and the group changes no state, when the free list holds fewer tags than the group has real destinations, or when the group has more valid lanes than there are free in-flight slots.
- R7: Accepted valid lanes get consecutive slot numbers in lane order, continuing from the last slot handed out (modulo DEPTH).
- R8: A flush to slot N restores the map as it stood right after N was renamed, drops every younger instruction, returns their new tags to the free list in that cycle, and makes N+1 the next slot. In a flush cycle no group is accepted and no commit occurs.
- R9: A commit retires the oldest in-flight instruction and returns its previous tag to the free list. Instructions with destination 31 free nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ren_valid | input | W | Lane valid mask of the rename group |
| ren_src1 | input | W*AW | First source register per lane |
| ren_src2 | input | W*AW | Second source register per lane |
| ren_dst | input | W*AW | Destination register per lane |
| ren_ready | output | 1 | Group is accepted at the next edge |
| ren_ps1 | output | W*PW | Physical tag of first source per lane |
| ren_ps2 | output | W*PW | Physical tag of second source per lane |
| ren_pd | output | W*PW | Newly allocated destination tag per lane |
| ren_pold | output | W*PW | Previous destination mapping per lane |
| ren_id | output | W*IW | In-flight slot number per lane |
| cmt_valid | input | 1 | Retire the oldest in-flight instruction |
| flush_valid | input | 1 | Roll back to slot flush_id |
| flush_id | input | IW | Youngest slot kept by the flush |

## Verification
The bench builds a group in which a later lane reads and rewrites the destination of an earlier lane. A design without intra-group forwarding would hand back the stale mapping and would later free a register that is still live. It flushes into the middle of in-flight work and then renames again: the next allocation must reuse a register returned by the flush, and the restored map must drop the younger writes. A design that leaked those registers, or reloaded the wrong snapshot, would give a different tag or a different slot number. It also drains the free list until a full group cannot fit, then resubmits that group with one destination on register 31. A design that counted the zero register as a destination would stall where it should accept.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int W      = 4,
  parameter int NARCH  = 32,
  parameter int NPHYS  = 40,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(NARCH),
  localparam int PW    = $clog2(NPHYS),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    ren_valid,
  input  logic [W*AW-1:0] ren_src1,
  input  logic [W*AW-1:0] ren_src2,
  input  logic [W*AW-1:0] ren_dst,
  output logic            ren_ready,
  output logic [W*PW-1:0] ren_ps1,
  output logic [W*PW-1:0] ren_ps2,
  output logic [W*PW-1:0] ren_pd,
  output logic [W*PW-1:0] ren_pold,
  output logic [W*IW-1:0] ren_id,
  input  logic            cmt_valid,
  input  logic            flush_valid,
  input  logic [IW-1:0]   flush_id
);
  localparam int ZR = NARCH - 1;
  localparam int CW = PW + IW + 2;

  logic [PW-1:0]    map_q  [NARCH];
  logic [PW-1:0]    snap_q [DEPTH][NARCH];
  logic [PW-1:0]    e_pd   [DEPTH];
  logic [PW-1:0]    e_pold [DEPTH];
  logic [DEPTH-1:0] e_hasd;
  logic [NPHYS-1:0] free_q;
  logic [IW-1:0]    head_q, tail_q;
  logic [IW:0]      cnt_q;

  logic [PW-1:0] alloc [W];
  logic [PW-1:0] lmap  [W][NARCH];
  logic [PW-1:0] pd    [W];
  logic [IW-1:0] id    [W];
  logic [W-1:0]  hasd;
  logic [CW-1:0] ndst, nval, nfree;
  logic [IW-1:0] fl_off;
  logic          cmt_ok;

  assign nfree  = CW'($countones(free_q));
  assign fl_off = flush_id - head_q;
  assign cmt_ok = cmt_valid && (cnt_q != '0);
  assign ren_ready = !flush_valid && (ndst <= nfree) &&
                     (nval <= CW'(DEPTH) - CW'(cnt_q));

  always_comb begin
    logic [NPHYS-1:0] tmp;
    tmp = free_q;
    for (int a = 0; a < W; a++) begin
      alloc[a] = '0;
      for (int p = NPHYS - 1; p >= 0; p--)
        if (tmp[p]) alloc[a] = PW'(p);
      tmp[alloc[a]] = 1'b0;
    end
  end

  always_comb begin
    logic [PW-1:0] cur [NARCH];
    logic [AW-1:0] s1, s2, d;
    int k, nv;
    cur = map_q;
    k = 0;
    nv = 0;
    for (int i = 0; i < W; i++) begin
      s1 = ren_src1[i*AW +: AW];
      s2 = ren_src2[i*AW +: AW];
      d  = ren_dst[i*AW +: AW];
      ren_ps1[i*PW +: PW] = cur[s1];
      ren_ps2[i*PW +: PW] = cur[s2];
      hasd[i] = ren_valid[i] && (d != AW'(ZR));
      id[i] = tail_q + IW'(nv);
      ren_id[i*IW +: IW] = id[i];
      if (ren_valid[i]) nv = nv + 1;
      pd[i] = '0;
      ren_pold[i*PW +: PW] = '0;
      if (hasd[i]) begin
        pd[i] = alloc[k];
        ren_pold[i*PW +: PW] = cur[d];
        cur[d] = alloc[k];
        k = k + 1;
      end
      ren_pd[i*PW +: PW] = pd[i];
      lmap[i] = cur;
    end
    ndst = CW'(k);
    nval = CW'(nv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NARCH; r++) map_q[r] <= (r == ZR) ? '0 : PW'(r + 1);
      for (int p = 0; p < NPHYS; p++) free_q[p] <= (p >= NARCH);
      for (int e = 0; e < DEPTH; e++) begin
        e_pd[e]   <= '0;
        e_pold[e] <= '0;
      end
      e_hasd <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_valid) begin
      map_q <= snap_q[flush_id];
      for (int e = 0; e < DEPTH; e++)
        if (((IW'(e) - head_q) > fl_off) && ({1'b0, IW'(e) - head_q} < cnt_q) && e_hasd[e])
          free_q[e_pd[e]] <= 1'b1;
      tail_q <= flush_id + 1'b1;
      cnt_q  <= {1'b0, fl_off} + 1'b1;
    end else begin
      if (ren_ready) begin
        map_q <= lmap[W-1];
        for (int i = 0; i < W; i++) begin
          if (hasd[i]) free_q[pd[i]] <= 1'b0;
          if (ren_valid[i]) begin
            e_pd[id[i]]   <= pd[i];
            e_pold[id[i]] <= ren_pold[i*PW +: PW];
            e_hasd[id[i]] <= hasd[i];
          end
        end
        tail_q <= tail_q + IW'(nval);
      end
      if (cmt_ok) begin
        if (e_hasd[head_q]) free_q[e_pold[head_q]] <= 1'b1;
        head_q <= head_q + 1'b1;
      end
      cnt_q <= cnt_q + (ren_ready ? (IW+1)'(nval) : '0) - (IW+1)'(cmt_ok);
    end
  end

  always_ff @(posedge clk)
    if (rst_n && ren_ready)
      for (int i = 0; i < W; i++)
        if (ren_valid[i]) snap_q[id[i]] <= lmap[i];

endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int W     = 4,
  parameter int NARCH = 32,
  parameter int NPHYS = 40,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(NARCH),
  localparam int PW   = $clog2(NPHYS),
  localparam int IW   = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    ren_valid,
  input logic [W*AW-1:0] ren_src1,
  input logic [W*AW-1:0] ren_dst,
  input logic            ren_ready,
  input logic [W*PW-1:0] ren_ps1,
  input logic [W*PW-1:0] ren_pd,
  input logic            flush_valid,
  input logic [IW:0]     cnt_q
);
  localparam int ZR = NARCH - 1;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= (IW+1)'(DEPTH)); // R6
  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) flush_valid |-> !ren_ready); // R8

  for (genvar i = 0; i < W; i++) begin : g_lane
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_src1[i*AW +: AW] == AW'(ZR)) |-> (ren_ps1[i*PW +: PW] == '0)); // R2
    AST_FRESH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid[i] && ren_dst[i*AW +: AW] != AW'(ZR) && ren_ready) |->
      (ren_pd[i*PW +: PW] != '0 && ren_pd[i*PW +: PW] >= PW'(NARCH - 0) - PW'(NARCH - 0) + 1'b1)); // R3
    for (genvar j = i + 1; j < W; j++) begin : g_pair
      AST_DISTINCT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid[i] && ren_valid[j] && ren_dst[i*AW +: AW] != AW'(ZR) &&
         ren_dst[j*AW +: AW] != AW'(ZR) && ren_ready) |->
        (ren_pd[i*PW +: PW] != ren_pd[j*PW +: PW])); // R3
    end
    if (i > 0) begin : g_fwd
      AST_GROUP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid[i] && ren_valid[i-1] && ren_dst[(i-1)*AW +: AW] != AW'(ZR) &&
         ren_src1[i*AW +: AW] == ren_dst[(i-1)*AW +: AW]) |->
        (ren_ps1[i*PW +: PW] == ren_pd[(i-1)*PW +: PW])); // R4
    end
  end
endmodule

bind rename_map rename_map_chk #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src1(ren_src1),
  .ren_dst(ren_dst), .ren_ready(ren_ready), .ren_ps1(ren_ps1), .ren_pd(ren_pd),
  .flush_valid(flush_valid), .cnt_q(cnt_q));

// File: tb/rename_map_tb_top.sv
`timescale 1ns/100ps
module rename_map_tb_top;
  localparam int W = 4, AW = 5, PW = 6, IW = 4;

  typedef struct packed {
    logic [3:0]       v;
    logic [3:0][4:0]  s1, s2, d;
    logic [3:0][5:0]  e1, e2, epd, epold;
    logic [3:0][3:0]  eid;
  } vec_t;

  localparam vec_t VECS [3] = '{
    '{v: 4'b1111,
      s1: {5'd31, 5'd3, 5'd3, 5'd1}, s2: {5'd3, 5'd4, 5'd31, 5'd2}, d: {5'd5, 5'd31, 5'd3, 5'd3},
      e1: {6'd0, 6'd33, 6'd32, 6'd2}, e2: {6'd33, 6'd5, 6'd0, 6'd3},
      epd: {6'd34, 6'd0, 6'd33, 6'd32}, epold: {6'd6, 6'd0, 6'd32, 6'd4},
      eid: {4'd3, 4'd2, 4'd1, 4'd0}},
    '{v: 4'b0101,
      s1: {5'd0, 5'd7, 5'd0, 5'd3}, s2: {5'd0, 5'd0, 5'd0, 5'd5}, d: {5'd0, 5'd0, 5'd0, 5'd7},
      e1: {6'd0, 6'd35, 6'd0, 6'd33}, e2: {6'd0, 6'd1, 6'd0, 6'd34},
      epd: {6'd0, 6'd36, 6'd0, 6'd35}, epold: {6'd0, 6'd1, 6'd0, 6'd8},
      eid: {4'd0, 4'd5, 4'd0, 4'd4}},
    '{v: 4'b0001,
      s1: {5'd0, 5'd0, 5'd0, 5'd0}, s2: {5'd0, 5'd0, 5'd0, 5'd7}, d: {5'd0, 5'd0, 5'd0, 5'd7},
      e1: {6'd0, 6'd0, 6'd0, 6'd36}, e2: {6'd0, 6'd0, 6'd0, 6'd35},
      epd: {6'd0, 6'd0, 6'd0, 6'd37}, epold: {6'd0, 6'd0, 6'd0, 6'd35},
      eid: {4'd0, 4'd0, 4'd0, 4'd6}}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] ren_valid = '0;
  logic [W*AW-1:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
  logic ren_ready;
  logic [W*PW-1:0] ren_ps1, ren_ps2, ren_pd, ren_pold;
  logic [W*IW-1:0] ren_id;
  logic cmt_valid = 1'b0, flush_valid = 1'b0;
  logic [IW-1:0] flush_id = '0;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rename_map dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v, input logic [3:0][4:0] s1, s2, d);
    ren_valid = v;
    ren_src1 = s1;
    ren_src2 = s2;
    ren_dst = d;
  endtask

  function automatic int lane(input logic [W*PW-1:0] bus, input int i);
    return int'(bus[i*PW +: PW]);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 R2 R6: reset mapping, zero register, ready with an empty window
    @(negedge clk);
    drive(4'b0000, {5'd0, 5'd0, 5'd31, 5'd10}, '0, '0);
    #1;
    check("R1 reset map r10", lane(ren_ps1, 0), 11);
    check("R2 zero source", lane(ren_ps1, 1), 0);
    check("R6 ready after reset", int'(ren_ready), 1);

    // R3 R4 R5 R7 R2: table of groups
    foreach (VECS[n]) begin
      @(negedge clk);
      drive(VECS[n].v, VECS[n].s1, VECS[n].s2, VECS[n].d);
      #1;
      check("R6 group accepted", int'(ren_ready), 1);
      for (int i = 0; i < W; i++) begin
        if (VECS[n].v[i]) begin
          check("R4 source one", lane(ren_ps1, i), int'(VECS[n].e1[i]));
          check("R1 source two", lane(ren_ps2, i), int'(VECS[n].e2[i]));
          check("R3 new dest", lane(ren_pd, i), int'(VECS[n].epd[i]));
          check("R5 previous dest", lane(ren_pold, i), int'(VECS[n].epold[i]));
          check("R7 slot", int'(ren_id[i*IW +: IW]), int'(VECS[n].eid[i]));
        end
      end
      @(posedge clk);
    end

    // R8: flush keeping slots 0..3
    @(negedge clk);
    drive(4'b0001, '0, '0, {5'd0, 5'd0, 5'd0, 5'd2});
    flush_valid = 1'b1;
    flush_id = 4'd3;
    #1;
    check("R8 no rename in flush cycle", int'(ren_ready), 0);
    @(posedge clk);
    @(negedge clk);
    flush_valid = 1'b0;
    drive(4'b0001, {5'd0, 5'd0, 5'd0, 5'd7}, {5'd0, 5'd0, 5'd0, 5'd0}, {5'd0, 5'd0, 5'd0, 5'd9});
    #1;
    check("R8 restored r7", lane(ren_ps1, 0), 8);
    check("R8 restored r0", lane(ren_ps2, 0), 1);
    check("R8 register reclaimed", lane(ren_pd, 0), 35);
    check("R8 previous dest", lane(ren_pold, 0), 10);
    check("R8 next slot", int'(ren_id[IW-1:0]), 4);
    @(posedge clk);

    // R9: retire slots 0..3, freeing 4, 32, 6
    @(negedge clk);
    ren_valid = '0;
    cmt_valid = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    cmt_valid = 1'b0;
    drive(4'b1111, {4{5'd31}}, {4{5'd31}}, {5'd6, 5'd4, 5'd2, 5'd1});
    #1;
    check("R9 freed tag lane0", lane(ren_pd, 0), 4);
    check("R9 freed tag lane1", lane(ren_pd, 1), 6);
    check("R9 freed tag lane2", lane(ren_pd, 2), 32);
    check("R3 lowest free lane3", lane(ren_pd, 3), 36);
    check("R3 previous r6", lane(ren_pold, 3), 7);
    check("R7 slot after commit", int'(ren_id[3*IW +: IW]), 8);
    @(posedge clk);

    // R6: three tags left, four destinations
    @(negedge clk);
    drive(4'b1111, {4{5'd31}}, {4{5'd31}}, {5'd13, 5'd12, 5'd11, 5'd10});
    #1;
    check("R6 stall on free list", int'(ren_ready), 0);
    @(posedge clk);

    // R2 R6: same group with one zero-register destination fits
    @(negedge clk);
    drive(4'b1111, {4{5'd31}}, {4{5'd31}}, {5'd31, 5'd12, 5'd11, 5'd10});
    #1;
    check("R6 accepted with three dests", int'(ren_ready), 1);
    check("R6 stall allocated nothing", lane(ren_pd, 0), 37);
    check("R3 lane2 dest", lane(ren_pd, 2), 39);
    check("R3 lane2 previous", lane(ren_pold, 2), 13);
    check("R2 zero dest tag", lane(ren_pd, 3), 0);
    check("R2 zero dest previous", lane(ren_pold, 3), 0);
    check("R7 slot lane3", int'(ren_id[3*IW +: IW]), 12);
    @(posedge clk);
    @(negedge clk);
    ren_valid = '0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #(200000 * 5);
    join_any
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule